// File: doc/BRIEF.md
# SPI Banked-Command Protocol Checker

This block is a passive observer on a four-wire SPI link to a peripheral whose command byte packs a 3-bit opcode above a 5-bit register address, and whose register file is split into banks picked by two select bits held in a bank control register. The block never drives the bus. It oversamples serial clock, data-in and chip select on the system clock, assembles the bytes sent to the peripheral, and judges each frame once chip select is released.

The checker keeps its own copy of the two bank-select bits. It follows them by watching full writes and masked set or clear operations aimed at the bank control register. Each bit is "unknown" from reset until some frame defines it. When a frame closes, the block raises a one-cycle report. The report carries the decoded opcode and address, the bank in force when the frame began, whether that bank was fully known, a length figure and a vector of violation flags. Two parameter tables, indexed by {bank, address}, mark which registers are reserved and which belong to the class that needs a dummy byte on reads.

Top module: `spi_cmd_checker`

## Requirements
- R1: A report (`rpt_valid` high for exactly one cycle) follows each release of chip select. A frame that held no complete byte yields no report.
- R2: Bits are taken on SCK rising edges while chip select is low, most significant bit first. Bits 7:5 of the first byte are reported as the opcode and bits 4:0 as the address. Trailing bits of an incomplete byte are discarded.
- R3: Opcode 110 is undefined. It sets error bit 0 and no other error bit.
- R4: Length rules: register write (010), bit set (100) and bit clear (101) need exactly 2 bytes, reset (111) exactly 1 byte, and register read (000) 2 or 3 bytes. Any other count sets error bit 1. When error bit 1 is set, the bank, dummy and reserved checks are skipped and the shadow bank is left unchanged.
- R5: Dummy-byte rules apply to a register read of valid length with the bank known. A dummy-class register read in 2 bytes sets error bit 2. Any other register read in 3 bytes sets error bit 3.
- R6: A buffer read (001) whose first byte is not 0x3A, or a buffer write (011) whose first byte is not 0x7A, sets error bit 4. For these two opcodes the reported length is the byte count minus one. For all other opcodes it is the byte count.
- R7: Both shadow bank bits are unknown after reset. A register access of valid length made while either bit is unknown sets error bit 5 and reports `rpt_bank_known` low.
- R8: A register write of valid length to address 0x1F loads both shadow bits from data bits 1:0. A bit set or bit clear of valid length to 0x1F sets or clears only the bits whose mask bit is 1, and marks those bits known. The reported bank is the value before the frame's own update.
- R9: A register access of valid length, with the bank known, to an address flagged reserved for that bank sets error bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Observed serial clock |
| spi_mosi | input | 1 | Observed data toward the peripheral |
| spi_cs_n | input | 1 | Observed chip select, active low |
| rpt_valid | output | 1 | One-cycle frame report strobe |
| rpt_opcode | output | 3 | Opcode of the frame's first byte |
| rpt_addr | output | 5 | Address of the frame's first byte |
| rpt_bank | output | 2 | Shadow bank at frame start |
| rpt_bank_known | output | 1 | Both shadow bank bits were known at frame start |
| rpt_len | output | 8 | Byte count, or data-byte count for buffer opcodes |
| rpt_err | output | 7 | Violation flags, bit positions as in R3 to R9 |

## Verification
The bench builds the checker with its default parameters. With those defaults the bank register sits at address 0x1F, address 0x1A is reserved in all four banks, and addresses 0x00 to 0x0A form the dummy-class group in banks 2 and 3 only. Because of this, a single stream of frames can walk the shadow bank through every state: first unknown, then half known, then banks 1, 2 and 3. The same stream reaches both dummy-byte outcomes, a reserved hit, and a rejected bit operation that must leave the bank untouched.

// File: rtl/spi_chk_pkg.sv
package spi_chk_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_RD_REG   = 3'd0,
        OP_RD_BUF   = 3'd1,
        OP_WR_REG   = 3'd2,
        OP_WR_BUF   = 3'd3,
        OP_SET_BITS = 3'd4,
        OP_CLR_BITS = 3'd5,
        OP_UNDEF    = 3'd6,
        OP_SOFT_RST = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_LOAD,
        UPD_SET,
        UPD_CLR
    } upd_e;

    // Packed MSB first: bad_reg is bit 6, bad_op is bit 0.
    typedef struct packed {
        logic bad_reg;
        logic bank_unk;
        logic bad_hdr;
        logic extra_dummy;
        logic no_dummy;
        logic bad_len;
        logic bad_op;
    } err_t;

    localparam logic [BYTE_W-1:0] HDR_RD_BUF = 8'h3A;
    localparam logic [BYTE_W-1:0] HDR_WR_BUF = 8'h7A;

    function automatic logic is_buf_op(input op_e op);
        return (op == OP_RD_BUF) || (op == OP_WR_BUF);
    endfunction

    function automatic logic is_reg_op(input op_e op);
        return (op == OP_RD_REG) || (op == OP_WR_REG) ||
               (op == OP_SET_BITS) || (op == OP_CLR_BITS);
    endfunction

endpackage

// File: rtl/spi_edge_rx.sv
module spi_edge_rx
    import spi_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_dat,
    output logic              frame_end
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic              sck_q, sck_p, mosi_q, act_q, act_p;
    logic [BIT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shnext;

    assign shnext    = {shreg[BYTE_W-2:0], mosi_q};
    assign frame_end = act_p & ~act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            sck_p    <= 1'b0;
            mosi_q   <= 1'b0;
            act_q    <= 1'b0;
            act_p    <= 1'b0;
            bitcnt   <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_dat <= '0;
        end else begin
            sck_q    <= sck;
            sck_p    <= sck_q;
            mosi_q   <= mosi;
            act_q    <= ~cs_n;
            act_p    <= act_q;
            byte_vld <= 1'b0;
            if (!act_q) begin
                bitcnt <= '0;
            end else if (sck_q && !sck_p) begin
                shreg  <= shnext;
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == BIT_W'(BYTE_W-1)) begin
                    byte_vld <= 1'b1;
                    byte_dat <= shnext;
                end
            end
        end
    end

    // R2: an idle chip select drops any partial byte
    a_r2_idle_clears: assert property (@(posedge clk) disable iff (rst)
        !act_q |=> (bitcnt == '0));

    // R1: a frame end never repeats on consecutive cycles
    a_r1_end_single: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

endmodule

// File: rtl/bank_shadow.sv
module bank_shadow
    import spi_chk_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  upd_e              upd_kind,
    input  logic [BANK_W-1:0] upd_bits,
    output logic [BANK_W-1:0] bank,
    output logic [BANK_W-1:0] known
);
    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i]  <= 1'b0;
                known[i] <= 1'b0;
            end else begin
                unique case (upd_kind)
                    UPD_LOAD: begin
                        bank[i]  <= upd_bits[i];
                        known[i] <= 1'b1;
                    end
                    UPD_SET: if (upd_bits[i]) begin
                        bank[i]  <= 1'b1;
                        known[i] <= 1'b1;
                    end
                    UPD_CLR: if (upd_bits[i]) begin
                        bank[i]  <= 1'b0;
                        known[i] <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        // R8: a known bit stays known until reset
        a_r8_known_sticky: assert property (@(posedge clk) disable iff (rst)
            known[i] |=> known[i]);

        // R8: a masked operation leaves unselected bits alone
        a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
            ((upd_kind == UPD_SET || upd_kind == UPD_CLR) && !upd_bits[i])
            |=> $stable(bank[i]));
    end

endmodule

// File: rtl/frame_eval.sv
module frame_eval
    import spi_chk_pkg::*;
#(
    parameter int                       ADDR_W   = 5,
    parameter int                       BANK_W   = 2,
    parameter int                       CNT_W    = 8,
    parameter logic [ADDR_W-1:0]        BANK_REG = 5'h1F,
    parameter logic [(1<<(BANK_W+ADDR_W))-1:0] RSV_MAP = '0,
    parameter logic [(1<<(BANK_W+ADDR_W))-1:0] DUM_MAP = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              frame_end,
    input  logic [BANK_W-1:0] bank,
    input  logic [BANK_W-1:0] known,
    output upd_e              upd_kind,
    output logic [BANK_W-1:0] upd_bits,
    output logic              rpt_valid,
    output op_e               rpt_op,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic [BANK_W-1:0] rpt_bank,
    output logic              rpt_known,
    output logic [CNT_W-1:0]  rpt_len,
    output err_t              rpt_err
);
    localparam int IDX_W = BANK_W + ADDR_W;

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] hdr;
    logic [BANK_W-1:0] dat1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hdr  <= '0;
            dat1 <= '0;
        end else if (frame_end) begin
            cnt <= '0;
        end else if (byte_vld) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(0)) hdr  <= byte_dat;
            if (cnt == CNT_W'(1)) dat1 <= byte_dat[BANK_W-1:0];
        end
    end

    op_e               op;
    logic [ADDR_W-1:0] adr;
    logic [IDX_W-1:0]  idx;
    logic              all_known, len_ok, reg_chk;
    err_t              err;
    upd_e              kind;
    logic              report;

    assign op        = op_e'(hdr[BYTE_W-1 -: OP_W]);
    assign adr       = hdr[ADDR_W-1:0];
    assign idx       = {bank, adr};
    assign all_known = &known;
    assign report    = frame_end && (cnt != '0);
    assign reg_chk   = is_reg_op(op) && len_ok;

    always_comb begin
        err    = '0;
        len_ok = 1'b1;
        kind   = UPD_NONE;
        unique case (op)
            OP_RD_REG:   len_ok = (cnt == CNT_W'(2)) || (cnt == CNT_W'(3));
            OP_WR_REG,
            OP_SET_BITS,
            OP_CLR_BITS: len_ok = (cnt == CNT_W'(2));
            OP_SOFT_RST: len_ok = (cnt == CNT_W'(1));
            OP_RD_BUF:   err.bad_hdr = (hdr != HDR_RD_BUF);
            OP_WR_BUF:   err.bad_hdr = (hdr != HDR_WR_BUF);
            default:     err.bad_op  = 1'b1;
        endcase
        err.bad_len = !len_ok;
        if (reg_chk) begin
            err.bank_unk = !all_known;
            if (all_known) begin
                err.bad_reg = RSV_MAP[idx];
                if (op == OP_RD_REG) begin
                    err.no_dummy    = DUM_MAP[idx] && (cnt != CNT_W'(3));
                    err.extra_dummy = !DUM_MAP[idx] && (cnt == CNT_W'(3));
                end
            end
            if (adr == BANK_REG) begin
                unique case (op)
                    OP_WR_REG:   kind = UPD_LOAD;
                    OP_SET_BITS: kind = UPD_SET;
                    OP_CLR_BITS: kind = UPD_CLR;
                    default:     kind = UPD_NONE;
                endcase
            end
        end
    end

    assign upd_kind = report ? kind : UPD_NONE;
    assign upd_bits = dat1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt_valid <= 1'b0;
            rpt_op    <= OP_RD_REG;
            rpt_addr  <= '0;
            rpt_bank  <= '0;
            rpt_known <= 1'b0;
            rpt_len   <= '0;
            rpt_err   <= '0;
        end else begin
            rpt_valid <= report;
            if (report) begin
                rpt_op    <= op;
                rpt_addr  <= adr;
                rpt_bank  <= bank;
                rpt_known <= all_known;
                rpt_len   <= is_buf_op(op) ? cnt - 1'b1 : cnt;
                rpt_err   <= err;
            end
        end
    end

    // R1: the report strobe lasts one cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |=> !rpt_valid);

    // R3: undefined opcode flags nothing else
    a_r3_undef_alone: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_op == OP_UNDEF) |-> (rpt_err == err_t'(7'b0000001)));

    // R4: a length fault suppresses register checks
    a_r4_len_masks: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_err.bad_len) |->
        !(rpt_err.bank_unk || rpt_err.bad_reg || rpt_err.no_dummy || rpt_err.extra_dummy));

    // R6: header faults only on buffer opcodes
    a_r6_hdr_scope: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_err.bad_hdr) |-> is_buf_op(rpt_op));

    // R7: unknown-bank flag agrees with the known output
    a_r7_unk_flag: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_err.bank_unk) |-> !rpt_known);

    // R9: reserved hits only reported with a known bank
    a_r9_rsv_known: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_err.bad_reg) |-> rpt_known);

endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker
    import spi_chk_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BANK_W = 2,
    parameter int CNT_W  = 8,
    parameter logic [ADDR_W-1:0] BANK_REG = 5'h1F,
    parameter logic [(1<<(BANK_W+ADDR_W))-1:0] RSV_MAP =
        128'h04000000_04000000_04000000_04000000,
    parameter logic [(1<<(BANK_W+ADDR_W))-1:0] DUM_MAP =
        128'h000007FF_000007FF_00000000_00000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              rpt_valid,
    output logic [OP_W-1:0]   rpt_opcode,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic [BANK_W-1:0] rpt_bank,
    output logic              rpt_bank_known,
    output logic [CNT_W-1:0]  rpt_len,
    output logic [6:0]        rpt_err
);
    logic              byte_vld, frame_end;
    logic [BYTE_W-1:0] byte_dat;
    logic [BANK_W-1:0] bank, known, upd_bits;
    upd_e              upd_kind;
    op_e               op_s;
    err_t              err_s;

    spi_edge_rx u_rx (
        .clk(clk), .rst(rst), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .frame_end(frame_end)
    );

    bank_shadow #(.BANK_W(BANK_W)) u_bank (
        .clk(clk), .rst(rst), .upd_kind(upd_kind), .upd_bits(upd_bits),
        .bank(bank), .known(known)
    );

    frame_eval #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CNT_W(CNT_W),
        .BANK_REG(BANK_REG), .RSV_MAP(RSV_MAP), .DUM_MAP(DUM_MAP)
    ) u_eval (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .frame_end(frame_end), .bank(bank), .known(known),
        .upd_kind(upd_kind), .upd_bits(upd_bits),
        .rpt_valid(rpt_valid), .rpt_op(op_s), .rpt_addr(rpt_addr),
        .rpt_bank(rpt_bank), .rpt_known(rpt_bank_known),
        .rpt_len(rpt_len), .rpt_err(err_s)
    );

    assign rpt_opcode = op_s;
    assign rpt_err    = err_s;

endmodule

// File: tb/tb_spi_cmd_checker.sv
module tb_spi_cmd_checker;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic       rpt_valid, rpt_bank_known;
    logic [2:0] rpt_opcode;
    logic [4:0] rpt_addr;
    logic [1:0] rpt_bank;
    logic [7:0] rpt_len;
    logic [6:0] rpt_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_checker dut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .rpt_valid(rpt_valid), .rpt_opcode(rpt_opcode), .rpt_addr(rpt_addr),
        .rpt_bank(rpt_bank), .rpt_bank_known(rpt_bank_known),
        .rpt_len(rpt_len), .rpt_err(rpt_err)
    );

    typedef struct packed {
        logic [2:0]  n;
        logic [31:0] b;     // first byte in [31:24]
        logic [2:0]  op;
        logic [4:0]  adr;
        logic [1:0]  bank;
        logic        kn;
        logic [7:0]  len;
        logic [6:0]  err;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{3'd2, 32'h0500_0000, 3'd0, 5'h05, 2'd0, 1'b0, 8'd2, 7'h20}, // R7 R2 unknown bank
        '{3'd2, 32'h9F01_0000, 3'd4, 5'h1F, 2'd0, 1'b0, 8'd2, 7'h20}, // R8 set bit0
        '{3'd2, 32'h45AA_0000, 3'd2, 5'h05, 2'd1, 1'b0, 8'd2, 7'h20}, // R7 half known
        '{3'd2, 32'hBF02_0000, 3'd5, 5'h1F, 2'd1, 1'b0, 8'd2, 7'h20}, // R8 clear bit1
        '{3'd2, 32'h0500_0000, 3'd0, 5'h05, 2'd1, 1'b1, 8'd2, 7'h00}, // R7 now known
        '{3'd2, 32'h5F02_0000, 3'd2, 5'h1F, 2'd1, 1'b1, 8'd2, 7'h00}, // R8 load bank 2
        '{3'd2, 32'h0300_0000, 3'd0, 5'h03, 2'd2, 1'b1, 8'd2, 7'h04}, // R5 missing dummy
        '{3'd3, 32'h0300_0000, 3'd0, 5'h03, 2'd2, 1'b1, 8'd3, 7'h00}, // R5 dummy ok
        '{3'd2, 32'h5F03_0000, 3'd2, 5'h1F, 2'd2, 1'b1, 8'd2, 7'h00}, // R8 load bank 3
        '{3'd3, 32'h1000_0000, 3'd0, 5'h10, 2'd3, 1'b1, 8'd3, 7'h08}, // R5 extra dummy
        '{3'd2, 32'h5A11_0000, 3'd2, 5'h1A, 2'd3, 1'b1, 8'd2, 7'h40}, // R9 reserved
        '{3'd4, 32'h0500_0000, 3'd0, 5'h05, 2'd3, 1'b1, 8'd4, 7'h02}, // R4 read too long
        '{3'd4, 32'h3A01_0203, 3'd1, 5'h1A, 2'd3, 1'b1, 8'd3, 7'h00}, // R6 buffer read
        '{3'd2, 32'h3B01_0000, 3'd1, 5'h1B, 2'd3, 1'b1, 8'd1, 7'h10}, // R6 bad header
        '{3'd3, 32'h7A01_0200, 3'd3, 5'h1A, 2'd3, 1'b1, 8'd2, 7'h00}, // R6 buffer write
        '{3'd1, 32'h7B00_0000, 3'd3, 5'h1B, 2'd3, 1'b1, 8'd0, 7'h10}, // R6 bad header
        '{3'd1, 32'hFF00_0000, 3'd7, 5'h1F, 2'd3, 1'b1, 8'd1, 7'h00}, // R4 reset ok
        '{3'd2, 32'hFF00_0000, 3'd7, 5'h1F, 2'd3, 1'b1, 8'd2, 7'h02}, // R4 reset too long
        '{3'd2, 32'hC000_0000, 3'd6, 5'h00, 2'd3, 1'b1, 8'd2, 7'h01}, // R3 undefined
        '{3'd3, 32'h9F01_0000, 3'd4, 5'h1F, 2'd3, 1'b1, 8'd3, 7'h02}, // R4 no update
        '{3'd2, 32'hBF01_0000, 3'd5, 5'h1F, 2'd3, 1'b1, 8'd2, 7'h00}, // R4 R8 bank held
        '{3'd3, 32'h0300_0000, 3'd0, 5'h03, 2'd2, 1'b1, 8'd3, 7'h00}, // R8 only bit0
        '{3'd1, 32'h4500_0000, 3'd2, 5'h05, 2'd2, 1'b1, 8'd1, 7'h02}  // R4 write short
    };

    int errors = 0;
    int checks = 0;
    logic got;
    logic [2:0] g_op; logic [4:0] g_adr; logic [1:0] g_bank;
    logic g_kn; logic [7:0] g_len; logic [6:0] g_err;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk); mosi = b[i]; sck = 1'b0;
            @(negedge clk);
            @(negedge clk); sck = 1'b1;
            @(negedge clk);
        end
        @(negedge clk); sck = 1'b0;
    endtask

    task automatic frame(input int n, input logic [31:0] b, input int tail_bits);
        got = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < n; k++) send_bits(b[31-8*k -: 8], 8);
        if (tail_bits > 0) send_bits(8'hA5, tail_bits);
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (rpt_valid && !got) begin
                got = 1'b1;
                g_op = rpt_opcode; g_adr = rpt_addr; g_bank = rpt_bank;
                g_kn = rpt_bank_known; g_len = rpt_len; g_err = rpt_err;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset no report", {31'd0, rpt_valid}, 32'd0);

        frame(0, 32'h0, 0);
        check("R1 empty frame no report", {31'd0, got}, 32'd0);
        frame(0, 32'h0, 5);
        check("R2 partial byte no report", {31'd0, got}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            frame(int'(VEC[v].n), VEC[v].b, 0);
            check($sformatf("R1 row %0d report seen", v), {31'd0, got}, 32'd1);
            check($sformatf("R2 row %0d opcode/addr", v), {24'd0, g_op, g_adr},
                  {24'd0, VEC[v].op, VEC[v].adr});
            check($sformatf("R8 row %0d bank/known", v), {29'd0, g_bank, g_kn},
                  {29'd0, VEC[v].bank, VEC[v].kn});
            check($sformatf("R6 row %0d len", v), {24'd0, g_len}, {24'd0, VEC[v].len});
            check($sformatf("R4 row %0d err", v), {25'd0, g_err}, {25'd0, VEC[v].err});
        end

        // R2: trailing bits after a full byte are discarded
        frame(1, 32'hFF00_0000, 3);
        check("R2 trailing bits len", {24'd0, g_len}, 32'd1);
        check("R2 trailing bits err", {25'd0, g_err}, 32'd0);

        // R7: reset returns the shadow bank to unknown
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        frame(2, 32'h45AA_0000, 0);
        check("R7 after reset err", {25'd0, g_err}, 32'h20);
        check("R7 after reset known", {31'd0, g_kn}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule